// File: doc/BRIEF.md
# Probe Rank Sorter

This block puts the one-deviation syndrome groups of a check-node unit into approximate reliability order. Each group is stood for by a single probe LLR taken from an edge's sorted input list, at list indices 3, 6, 9 and 12. Only the probe decides where its group of three neighbouring syndromes lands. The LLRs of the neighbours are never looked at.

The probes arrive two per edge per cycle. The first half, probe slots 0 and 1, comes in the cycle that carries the start pulse. The second half, slots 2 and 3, comes in the cycle that follows. The block does not store probe values downstream. It ranks the probes and keeps a shifting list of their positions. From the cycle after start, it hands the positions of the two most reliable remaining probes to a multiplexer selector in each cycle.

Inside one edge, the two probes that arrive together are already in order. The ranking logic uses this and makes no comparison between them. A probe that has been handed out leaves the list by a shift of two places.

Top module: `probe_rank_sorter`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released, `out_valid_o` is 0. A reset in the middle of a run clears the run.
- R2: A position is 4 bits wide: bits [3:2] hold the edge number (0..3) and bits [1:0] hold the probe slot (0..3). Slots 0, 1, 2 and 3 mean list indices 3, 6, 9 and 12. In `llr_i`, the probe of edge e and cycle-local slot s sits at bits [(2e+s)*8 +: 8].
- R3: In the cycle after `start_i`, `out_valid_o` is 1, and `pos0_o`/`pos1_o` give the first and second probe of the run's overall order.
- R4: The order of a run is ascending probe LLR. Over 8 consecutive valid cycles, `pos0_o` and then `pos1_o` give overall ranks 2k and 2k+1 in cycle k (k = 0..7).
- R5: Equal LLRs are ordered by the lower edge number first, and within one edge by the lower slot first.
- R6: After all 16 probes have been handed out, `out_valid_o` stays 0 until the next `start_i`.
- R7: `llr_i` is ignored in every cycle except the start cycle and the one that follows it. With no run active, it has no effect on the outputs.
- R8: A `start_i` during a run drops the remaining probes. The new run's ranks 0 and 1 appear in the next cycle.
- R9: In every valid cycle, the two positions differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run; `llr_i` carries probe slots 0 and 1 in this cycle |
| llr_i | input | 64 | Eight probe LLRs, two per edge (slots 0/1 at start, 2/3 in the next cycle) |
| out_valid_o | output | 1 | Both positions are valid |
| pos0_o | output | 4 | Position of the most reliable remaining probe |
| pos1_o | output | 4 | Position of the second most reliable remaining probe |

## Verification
The assertions take for granted that each edge's four probe LLRs never decrease from slot 0 to slot 3, as they would when taken from a sorted input list. The ordering and tie checks within a cycle rely on this property. They also take for granted that the second half follows the start cycle directly. Every row of the stimulus table is non-decreasing per edge, and the second half is always driven in the cycle after start. Arbitrary values go onto `llr_i` only in cycles where the block must ignore it.

// File: rtl/prs_pkg.sv
`timescale 1ns/1ps
package prs_pkg;
    parameter int unsigned EDGES   = 4;
    parameter int unsigned SLOTS   = 4;
    parameter int unsigned PER_CYC = 2;
    parameter int unsigned LLR_W   = 8;

    localparam int unsigned EDGE_W = $clog2(EDGES);
    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam int unsigned POS_W  = EDGE_W + SLOT_W;
    localparam int unsigned BLK    = EDGES * PER_CYC;
    localparam int unsigned TOTAL  = EDGES * SLOTS;
    localparam int unsigned LOADS  = SLOTS / PER_CYC;
    localparam int unsigned OUT_PER = 2;
    localparam int unsigned LOAD_W = $clog2(LOADS + 1);

    typedef struct packed {
        logic              vld;
        logic [EDGE_W-1:0] edge_id;
        logic [SLOT_W-1:0] slot;
        logic [LLR_W-1:0]  llr;
    } probe_t;

    // a precedes b: valid before empty, then LLR, then edge, then slot
    function automatic logic ahead(input probe_t a, input probe_t b);
        if (!a.vld) return 1'b0;
        if (!b.vld) return 1'b1;
        return {a.llr, a.edge_id, a.slot} < {b.llr, b.edge_id, b.slot};
    endfunction
endpackage

// File: rtl/prs_block_sort.sv
`timescale 1ns/1ps
// Ranks one block of probes (PER_CYC per edge); pairs from one edge are
// known to be ordered, so no comparator is spent on them.
module prs_block_sort
    import prs_pkg::*;
(
    input  logic [BLK*LLR_W-1:0]     llr_i,
    input  logic [SLOT_W-1:0]        base_slot_i,
    output probe_t [BLK-1:0]         sorted_o
);
    localparam int unsigned RANK_W = $clog2(BLK) + 1;

    probe_t [BLK-1:0]    item;
    logic   [RANK_W-1:0] rank [BLK];

    for (genvar k = 0; k < BLK; k++) begin : g_item
        assign item[k].vld     = 1'b1;
        assign item[k].edge_id = EDGE_W'(k / PER_CYC);
        assign item[k].slot    = base_slot_i + SLOT_W'(k % PER_CYC);
        assign item[k].llr     = llr_i[k*LLR_W +: LLR_W];
    end

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            rank[k] = '0;
            for (int m = 0; m < BLK; m++) begin
                if (m != k) begin
                    if ((m / PER_CYC) == (k / PER_CYC))
                        rank[k] = rank[k] + RANK_W'((m % PER_CYC) < (k % PER_CYC));
                    else
                        rank[k] = rank[k] + RANK_W'(ahead(item[m], item[k]));
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < BLK; r++) begin
            sorted_o[r] = '0;
            for (int k = 0; k < BLK; k++) begin
                if (rank[k] == RANK_W'(r)) sorted_o[r] = item[k];
            end
        end
    end
endmodule

// File: rtl/prs_merge.sv
`timescale 1ns/1ps
// Merges the remaining sorted list (valid prefix) with a freshly ranked block.
module prs_merge
    import prs_pkg::*;
(
    input  probe_t [TOTAL-1:0] keep_i,
    input  probe_t [BLK-1:0]   blk_i,
    output probe_t [TOTAL-1:0] merged_o
);
    localparam int unsigned RW = $clog2(TOTAL + BLK) + 1;

    logic [RW-1:0] ra [TOTAL];
    logic [RW-1:0] rb [BLK];

    always_comb begin
        for (int i = 0; i < TOTAL; i++) begin
            ra[i] = RW'(i);
            for (int j = 0; j < BLK; j++)
                ra[i] = ra[i] + RW'(ahead(blk_i[j], keep_i[i]));
        end
        for (int j = 0; j < BLK; j++) begin
            rb[j] = RW'(j);
            for (int i = 0; i < TOTAL; i++)
                rb[j] = rb[j] + RW'(ahead(keep_i[i], blk_i[j]));
        end
    end

    always_comb begin
        for (int r = 0; r < TOTAL; r++) begin
            merged_o[r] = '0;
            for (int i = 0; i < TOTAL; i++)
                if (keep_i[i].vld && ra[i] == RW'(r)) merged_o[r] = keep_i[i];
            for (int j = 0; j < BLK; j++)
                if (blk_i[j].vld && rb[j] == RW'(r)) merged_o[r] = blk_i[j];
        end
    end
endmodule

// File: rtl/probe_rank_sorter.sv
`timescale 1ns/1ps
module probe_rank_sorter
    import prs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [BLK*LLR_W-1:0] llr_i,
    output logic                 out_valid_o,
    output logic [POS_W-1:0]     pos0_o,
    output logic [POS_W-1:0]     pos1_o
);
    typedef struct packed {
        probe_t [TOTAL-1:0] list;
        logic [LOAD_W-1:0]  loads_left;
    } st_t;

    st_t st_d, st_q;

    probe_t [TOTAL-1:0] shifted;
    probe_t [TOTAL-1:0] keep;
    probe_t [TOTAL-1:0] merged;
    probe_t [BLK-1:0]   blk_sorted;
    logic   [SLOT_W-1:0] base_slot;

    // consumed probes leave by a shift of OUT_PER places
    for (genvar i = 0; i < TOTAL; i++) begin : g_shift
        if (i + OUT_PER < TOTAL) begin : g_mv
            assign shifted[i] = st_q.list[i + OUT_PER];
        end else begin : g_zero
            assign shifted[i] = '0;
        end
    end

    assign base_slot = start_i ? '0
                     : SLOT_W'((LOADS - int'(st_q.loads_left)) * PER_CYC);
    assign keep      = start_i ? '0 : shifted;

    prs_block_sort u_bsort (
        .llr_i       (llr_i),
        .base_slot_i (base_slot),
        .sorted_o    (blk_sorted)
    );

    prs_merge u_merge (
        .keep_i   (keep),
        .blk_i    (blk_sorted),
        .merged_o (merged)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.list       = merged;
            st_d.loads_left = LOAD_W'(LOADS - 1);
        end else if (st_q.list[0].vld) begin
            if (st_q.loads_left != '0) begin
                st_d.list       = merged;
                st_d.loads_left = st_q.loads_left - 1'b1;
            end else begin
                st_d.list = shifted;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.list[0].vld;
    assign pos0_o      = {st_q.list[0].edge_id, st_q.list[0].slot};
    assign pos1_o      = {st_q.list[1].edge_id, st_q.list[1].slot};
endmodule

// File: rtl/prs_checker.sv
`timescale 1ns/1ps
module prs_checker
    import prs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             out_valid_o,
    input logic [POS_W-1:0] pos0_o,
    input logic [POS_W-1:0] pos1_o
);
    localparam int unsigned PAIRS = TOTAL / OUT_PER;
    logic [$clog2(PAIRS+1)-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_cnt <= '0;
        else if (start_i)     run_cnt <= '0;
        else if (out_valid_o) run_cnt <= run_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid_o); // R1
    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> out_valid_o); // R3
    AST_DISTINCT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> pos0_o != pos1_o); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid_o && !start_i) |=> !out_valid_o); // R6
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> run_cnt < PAIRS); // R6
    AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && run_cnt == PAIRS - 1 && !start_i) |=> !out_valid_o); // R4
    AST_SAME_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && pos0_o[POS_W-1:SLOT_W] == pos1_o[POS_W-1:SLOT_W])
        |-> pos0_o[SLOT_W-1:0] < pos1_o[SLOT_W-1:0]); // R5
endmodule

bind probe_rank_sorter prs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .out_valid_o (out_valid_o),
    .pos0_o      (pos0_o),
    .pos1_o      (pos1_o)
);

// File: tb/probe_rank_sorter_test.sv
`timescale 1ns/1ps
module probe_rank_sorter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] llr_i = '0;
    logic        out_valid_o;
    logic [3:0]  pos0_o, pos1_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    probe_rank_sorter uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .llr_i(llr_i),
        .out_valid_o(out_valid_o), .pos0_o(pos0_o), .pos1_o(pos1_o)
    );

    // rows: index e*4+slot; every edge non-decreasing
    localparam int NROW = 5;
    localparam logic [7:0] VEC [NROW][16] = '{
        '{8'd1, 8'd20, 8'd40, 8'd90,   8'd5, 8'd6, 8'd7, 8'd200,
          8'd0, 8'd50, 8'd51, 8'd52,   8'd10, 8'd11, 8'd100, 8'd255},
        '{8'd30, 8'd30, 8'd30, 8'd30,  8'd30, 8'd30, 8'd30, 8'd30,
          8'd30, 8'd30, 8'd30, 8'd30,  8'd30, 8'd30, 8'd30, 8'd30},
        '{8'd200, 8'd210, 8'd220, 8'd230, 8'd0, 8'd0, 8'd0, 8'd0,
          8'd0, 8'd1, 8'd2, 8'd3,         8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd3, 8'd3, 8'd9, 8'd9,      8'd3, 8'd4, 8'd9, 8'd9,
          8'd2, 8'd3, 8'd9, 8'd10,     8'd3, 8'd3, 8'd8, 8'd9},
        '{8'd0, 8'd0, 8'd255, 8'd255,  8'd0, 8'd255, 8'd255, 8'd255,
          8'd0, 8'd0, 8'd0, 8'd255,    8'd255, 8'd255, 8'd255, 8'd255}
    };

    logic [3:0] exp_ord [16];

    // reference order from R4/R5: key {llr, edge, slot}, position = e*4+slot
    task automatic build_ref(input int row);
        bit used [16];
        for (int c = 0; c < 16; c++) used[c] = 0;
        for (int r = 0; r < 16; r++) begin
            int best = -1;
            for (int c = 0; c < 16; c++) begin
                if (!used[c]) begin
                    if (best < 0) best = c;
                    else if ({VEC[row][c], 4'(c)} < {VEC[row][best], 4'(best)}) best = c;
                end
            end
            used[best] = 1;
            exp_ord[r] = 4'(best);
        end
    endtask

    task automatic drive_half(input int row, input int half);
        for (int e = 0; e < 4; e++)
            for (int s = 0; s < 2; s++)
                llr_i[(e*2+s)*8 +: 8] = VEC[row][e*4 + half*2 + s];
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [11:0] act, input logic [11:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // called at a negedge; checks npairs output cycles, returns at a negedge
    task automatic run_row(input int row, input int npairs, input string tag);
        build_ref(row);
        start_i = 1'b1;
        drive_half(row, 0);
        for (int k = 0; k < npairs; k++) begin
            @(negedge clk);
            check(out_valid_o && pos0_o == exp_ord[2*k] && pos1_o == exp_ord[2*k+1],
                  (k == 0) ? "R3" : tag, $sformatf("R2 row %0d pair %0d", row, k),
                  {out_valid_o, 3'b0, pos0_o, pos1_o},
                  {1'b1, 3'b0, exp_ord[2*k], exp_ord[2*k+1]});
            start_i = 1'b0;
            if (k == 0) drive_half(row, 1);
            else        llr_i = {$urandom, $urandom}; // R7: must be ignored
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid_o, "R1", "valid during reset", {11'b0, out_valid_o}, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o, "R1", "valid after reset", {11'b0, out_valid_o}, 12'h0);

        // R7: idle garbage has no effect
        for (int i = 0; i < 4; i++) begin
            llr_i = {$urandom, $urandom};
            @(negedge clk);
        end
        check(!out_valid_o, "R7", "idle inputs", {11'b0, out_valid_o}, 12'h0);

        // table walk: full runs (R4, R5 on the tie rows), then idle (R6)
        for (int row = 0; row < NROW; row++) begin
            run_row(row, 8, (row == 1 || row == 3) ? "R5" : "R4");
            @(negedge clk);
            check(!out_valid_o, "R6", $sformatf("idle after row %0d", row),
                  {11'b0, out_valid_o}, 12'h0);
            llr_i = {$urandom, $urandom};
            @(negedge clk);
            check(!out_valid_o, "R6", "stays idle", {11'b0, out_valid_o}, 12'h0);
        end

        // R8: restart after three pairs
        run_row(0, 3, "R4");
        run_row(2, 8, "R8");
        @(negedge clk);
        check(!out_valid_o, "R8", "idle after restarted run", {11'b0, out_valid_o}, 12'h0);

        // R1: reset in the middle of a run
        run_row(3, 2, "R4");
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid_o, "R1", "reset mid run", {11'b0, out_valid_o}, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid_o, "R1", "after mid-run reset", {11'b0, out_valid_o}, 12'h0);

        // R9 via a fresh run after reset
        run_row(4, 8, "R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule